// File: doc/BRIEF.md
# Unsigned Decimal Vector Shifter

This unit moves a 128-bit vector of 32 unsigned packed-BCD digits left or right by a whole number of decimal digits. No nibble is a sign code: all 32 nibbles are digits, including the lowest one. The shift count is a signed byte taken from a second 128-bit operand. A positive count moves digits toward the more significant end. A negative count moves them toward the less significant end. Vacated digit positions are filled with zero.

Each operation is marked by `in_valid`. The result and a 4-bit condition field appear one clock later with `out_valid`. The condition field compares the result with zero and carries a summary-overflow bit. That bit is raised when a nonzero digit is pushed off the top, when the count saturates on the left, or when the source holds a nibble that is not a decimal digit.

Top module: `udsh_unit`

## Requirements
- R1: If any source nibble is greater than 9, `cond` is 4'b0001 (only SO set) and `result` equals the source operand unchanged.
- R2: For a count c in 1..31, `result` is the source shifted toward the more significant end by 4*c bits, with the low c digits set to zero.
- R3: For a count in 1..31, SO (`cond[0]`) is set exactly when at least one nonzero digit leaves the top of the vector.
- R4: For a count c in -31..0, `result` is the source shifted toward the less significant end by 4*|c| bits, with zeros entering at the top. Digits that leave at the bottom never set SO.
- R5: A count of +32 or greater gives an all-zero `result` with SO set.
- R6: A count of -32 or less gives an all-zero `result` with SO clear.
- R7: The count is `shift_opnd[7:0]` read as a two's-complement byte. Bits [127:8] have no effect on the outcome.
- R8: For a valid source, `cond` is {LT, GT, EQ, SO} from bit 3 down to bit 0. LT is always 0, GT is 1 when `result` is nonzero, and EQ is 1 when `result` is zero.
- R9: `out_valid` rises one clock after an accepted `in_valid`. `result` and `cond` keep their values on cycles without `in_valid`.
- R10: While reset is asserted, and until the first operation after it, `out_valid`, `result` and `cond` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| in_valid | input | 1 | Marks an operation on the current inputs |
| src_digits | input | 128 | 32 unsigned BCD digits; bits [3:0] hold the least significant digit |
| shift_opnd | input | 128 | Holds the signed digit count in bits [7:0] |
| out_valid | output | 1 | Result and condition are valid |
| result | output | 128 | Shifted digit vector |
| cond | output | 4 | {LT, GT, EQ, SO} |

## Verification
The hardest case to reach from the ports is the overflow boundary: SO must appear only when the highest nonzero digit sits exactly at or above position 32-c. Full random vectors almost always overflow, so they say little about this edge. The bench therefore places a single nonzero digit at each of the 32 positions and sweeps every count from -40 to +40 for each position. This drives the lost-digit test through its exact edge on both sides. Full-width patterns then sweep all 256 byte counts, with noise in the upper shift-operand bits, and invalid nibbles are injected at every digit position.

// File: rtl/udsh_pkg.sv
package udsh_pkg;
  localparam int unsigned DIGIT_W   = 4;
  localparam int unsigned MAX_DIGIT = 9;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } udsh_cond_t;

  localparam udsh_cond_t COND_BAD = '{lt: 1'b0, gt: 1'b0, eq: 1'b0, so: 1'b1};
endpackage

// File: rtl/udsh_rst_sync.sv
module udsh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/udsh_digit_check.sv
module udsh_digit_check
  import udsh_pkg::*;
#(
  parameter int unsigned DIGITS = 32
) (
  input  logic [DIGITS*DIGIT_W-1:0] digits,
  output logic [DIGITS-1:0]         digit_nz,
  output logic                      any_bad
);
  logic [DIGITS-1:0] bad_vec;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [DIGIT_W-1:0] d;
    assign d          = digits[g*DIGIT_W +: DIGIT_W];
    assign bad_vec[g] = (d > DIGIT_W'(MAX_DIGIT));
    assign digit_nz[g] = (d != '0);
  end

  assign any_bad = |bad_vec;
endmodule

// File: rtl/udsh_shift_core.sv
module udsh_shift_core
  import udsh_pkg::*;
#(
  parameter int unsigned DIGITS = 32,
  parameter int unsigned CNT_W  = 8
) (
  input  logic [DIGITS*DIGIT_W-1:0] src,
  input  logic [DIGITS-1:0]         digit_nz,
  input  logic [CNT_W-1:0]          count,
  output logic [DIGITS*DIGIT_W-1:0] shifted,
  output logic                      overflow
);
  localparam int unsigned W    = DIGITS * DIGIT_W;
  localparam int unsigned SH_W = $clog2(DIGITS);

  logic             is_neg;
  logic             is_left;
  logic [CNT_W-1:0] mag;
  logic             sat;
  logic [SH_W-1:0]  shamt;
  logic [DIGITS-1:0] lost;

  logic [W-1:0] lstg [SH_W+1];
  logic [W-1:0] rstg [SH_W+1];

  always_comb begin
    is_neg  = count[CNT_W-1];
    is_left = !is_neg && (count != '0);
    mag     = is_neg ? (~count + 1'b1) : count;
    sat     = (mag >= CNT_W'(DIGITS));
    shamt   = mag[SH_W-1:0];
  end

  assign lstg[0] = src;
  assign rstg[0] = src;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    assign lstg[k+1] = shamt[k] ? (lstg[k] << (DIGIT_W << k)) : lstg[k];
    assign rstg[k+1] = shamt[k] ? (rstg[k] >> (DIGIT_W << k)) : rstg[k];
  end

  for (genvar i = 0; i < DIGITS; i++) begin : g_lost
    logic [SH_W:0] dest;
    assign dest    = {1'b0, shamt} + (SH_W+1)'(i);
    assign lost[i] = digit_nz[i] && (dest >= (SH_W+1)'(DIGITS));
  end

  always_comb begin
    if (sat)          shifted = '0;
    else if (is_left) shifted = lstg[SH_W];
    else              shifted = rstg[SH_W];
    overflow = is_left && (sat || (|lost));
  end
endmodule

// File: rtl/udsh_unit.sv
module udsh_unit
  import udsh_pkg::*;
#(
  parameter int unsigned DIGITS = 32,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [DIGITS*DIGIT_W-1:0] src_digits,
  input  logic [DIGITS*DIGIT_W-1:0] shift_opnd,
  output logic                      out_valid,
  output logic [DIGITS*DIGIT_W-1:0] result,
  output logic [3:0]                cond
);
  localparam int unsigned W = DIGITS * DIGIT_W;

  logic              rst_s_n;
  logic [DIGITS-1:0] digit_nz;
  logic              any_bad;
  logic [W-1:0]      shifted;
  logic              overflow;

  logic [W-1:0]      result_d;
  udsh_cond_t        cond_d;
  udsh_cond_t        cond_q;
  logic              valid_d;

  udsh_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  udsh_digit_check #(.DIGITS(DIGITS)) u_check (
    .digits   (src_digits),
    .digit_nz (digit_nz),
    .any_bad  (any_bad)
  );

  udsh_shift_core #(.DIGITS(DIGITS), .CNT_W(CNT_W)) u_core (
    .src      (src_digits),
    .digit_nz (digit_nz),
    .count    (shift_opnd[CNT_W-1:0]),
    .shifted  (shifted),
    .overflow (overflow)
  );

  always_comb begin
    valid_d = in_valid;
    if (any_bad) begin
      result_d = src_digits;
      cond_d   = COND_BAD;
    end else begin
      result_d  = shifted;
      cond_d.lt = 1'b0;
      cond_d.gt = (shifted != '0);
      cond_d.eq = (shifted == '0);
      cond_d.so = overflow;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) out_valid <= 1'b0;
    else          out_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      result <= '0;
      cond_q <= '0;
    end else if (in_valid) begin
      result <= result_d;
      cond_q <= cond_d;
    end
  end

  assign cond = cond_q;

  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_valid |=> out_valid);

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !in_valid |=> ($stable(result) && $stable(cond)));

  // R8
  lt_clear_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid |-> (cond[3] == 1'b0));

  // R8
  eq_zero_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && cond[1]) |-> (result == '0 && !cond[2]));

  // R1
  bad_pass_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && cond == 4'b0001) |-> (result == $past(src_digits)));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && $past(shift_opnd[CNT_W-1]) && (cond[2] || cond[1])) |-> !cond[0]);
endmodule

// File: tb/udsh_unit_bench.sv
module udsh_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 32;
  localparam int W  = ND * 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] src_digits;
  logic [W-1:0] shift_opnd;
  logic         out_valid;
  logic [W-1:0] result;
  logic [3:0]   cond;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  udsh_unit u_udsh_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .src_digits (src_digits),
    .shift_opnd (shift_opnd),
    .out_valid  (out_valid),
    .result     (result),
    .cond       (cond)
  );

  function automatic logic [W+3:0] model(logic [W-1:0] s, logic [W-1:0] a);
    int c;
    logic [W-1:0] r;
    bit ovf;
    bit bad;
    c   = int'($signed(a[7:0]));
    r   = '0;
    ovf = 0;
    bad = 0;
    for (int i = 0; i < ND; i++)
      if (s[i*4 +: 4] > 4'd9) bad = 1;
    if (bad) return {4'b0001, s};
    if (c >= ND) ovf = 1;
    else if (c > -ND) begin
      for (int i = 0; i < ND; i++) begin
        int j;
        j = i + c;
        if (j >= 0 && j < ND) r[j*4 +: 4] = s[i*4 +: 4];
        else if (j >= ND && s[i*4 +: 4] != 4'd0) ovf = 1;
      end
    end
    return {1'b0, (r != '0), (r == '0), ovf, r};
  endfunction

  task automatic check(bit ok, string req, logic [W+3:0] act, logic [W+3:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(logic [W-1:0] s, logic [W-1:0] a);
    int c;
    c = int'($signed(a[7:0]));
    for (int i = 0; i < ND; i++)
      if (s[i*4 +: 4] > 4'd9) return "R1";
    if (c >= ND) return "R5";
    if (c <= -ND) return "R6";
    if (c > 0) return "R2/R3";
    return "R4";
  endfunction

  task automatic run_op(logic [W-1:0] s, logic [W-1:0] a, string tag);
    logic [W+3:0] exp;
    @(negedge clk);
    in_valid   = 1'b1;
    src_digits = s;
    shift_opnd = a;
    @(negedge clk);
    in_valid = 1'b0;
    exp = model(s, a);
    check(out_valid === 1'b1, "R9 out_valid", {3'b0, out_valid, {W{1'b0}}}, {4'b0001, {W{1'b0}}});
    // R8 field order and R2..R7 data
    check({cond, result} === exp, tag, {cond, result}, exp);
  endtask

  function automatic logic [W-1:0] bcd_pattern(int seed);
    logic [W-1:0] p;
    for (int i = 0; i < ND; i++) p[i*4 +: 4] = 4'((i * 7 + seed) % 10);
    return p;
  endfunction

  initial begin
    logic [W-1:0] s;
    logic [W-1:0] noise;
    logic [W+3:0] held;
    rst_n = 1'b0;
    in_valid = 1'b0;
    src_digits = '0;
    shift_opnd = '0;
    repeat (3) @(negedge clk);
    // R10 during reset
    check({out_valid, cond, result} === '0, "R10 in reset", {cond, result}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({out_valid, cond, result} === '0, "R10 after release", {cond, result}, '0);

    // Overflow boundary: one nonzero digit at every position, counts -40..40
    for (int p = 0; p < ND; p++) begin
      for (int c = -40; c <= 40; c++) begin
        s = '0;
        s[p*4 +: 4] = 4'd7;
        run_op(s, W'(8'(c)), req_of(s, W'(8'(c))));
      end
    end

    // Full patterns, all byte counts, upper operand bits noisy (R7)
    for (int k = 0; k < 4; k++) begin
      s = bcd_pattern(k * 3);
      if (k == 3) s = '0;
      for (int c = 0; c < 256; c++) begin
        noise = {W{1'b1}} ^ (W'(k) << 40) ^ (W'(c) << 99);
        noise[7:0] = 8'(c);
        run_op(s, noise, {"R7 ", req_of(s, noise)});
      end
    end

    // R1: invalid nibble at each position, values A..F
    for (int p = 0; p < ND; p++) begin
      s = bcd_pattern(p);
      s[p*4 +: 4] = 4'(10 + (p % 6));
      run_op(s, W'(8'(p - 16)), "R1");
    end

    // R9: hold while idle with inputs changing
    run_op(bcd_pattern(5), W'(8'd3), "R2");
    held = {cond, result};
    @(negedge clk);
    src_digits = '1;
    shift_opnd = W'(8'd200);
    @(negedge clk);
    check({cond, result} === held, "R9 hold", {cond, result}, held);
    check(out_valid === 1'b0, "R9 out_valid low", {3'b0, out_valid, {W{1'b0}}}, '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule